// File: doc/BRIEF.md
# Radio Operating-Mode and RF-Switch Controller

This block sequences the operating modes of a low-power packet radio. Six modes exist: Off, Idle, Hibernate, Doze, Receive and Transmit. Receive and transmit each have a warm-up phase and an active phase. The host selects a low-power mode through a request field. It starts a receive or a transmit by raising an external enable pin, with the direction chosen by a configuration bit beforehand. An active-low attention pin wakes the radio from either low-power mode.

The block also drives the control line of an external RF switch or amplifier. The line carries a value and an output enable. Its level follows the current mode, the port arrangement (single or dual) and a polarity bit. The polarity bit matters only in dual-port operation.

The reset pin, the enable pin and the attention pin are asynchronous, and each passes through a two-stage synchronizer. The request field, the direction bit, the end-of-sequence strobe and the switch configuration bits are synchronous to the clock.

Top module: `radio_mode_ctrl`

## Requirements
- R1: While rst_n is low, mode_o is Off (0), and out_of_idle_o, rfctl_oe_o, rfctl_o, seq_done_o and seq_abort_o are all 0. After rst_n rises, mode_o becomes Idle on the third rising clock edge.
- R2: mode_o is encoded as follows: 0 Off, 1 Idle, 2 Hibernate, 3 Doze, 4 receive warm-up, 5 receive active, 6 transmit warm-up, 7 transmit active.
- R3: In Idle, with attention inactive and no enable edge pending, lp_req_i = 2'b01 enters Hibernate and lp_req_i = 2'b10 enters Doze on the next edge. The values 2'b00 and 2'b11 keep Idle. Low-power modes are entered only from Idle.
- R4: A low level on attn_n_i brings Hibernate or Doze back to Idle on the third edge after the pin falls. While attention is low, Idle does not enter a low-power mode.
- R5: A rising edge of rxtx_en_i seen in Idle starts a warm-up on the third edge after the pin rises. seq_tx_i = 0 selects receive warm-up (4) and seq_tx_i = 1 selects transmit warm-up (6). The edge takes priority over a low-power request. Edges seen in any other mode are ignored, and a pin that stays high does not start a new sequence.
- R6: A warm-up lasts exactly WARMUP_CYCLES clock cycles, after which the active phase of the same direction is entered. The default of 2304 cycles equals 144 µs at 16 MHz.
- R7: In an active phase, with the enable pin still high, seq_end_i returns the mode to Idle on the next edge. seq_done_o pulses high for exactly one cycle at that edge.
- R8: A synchronized low level on rxtx_en_i during warm-up or an active phase returns the mode to Idle with no seq_done_o pulse, and sets seq_abort_o. seq_abort_o stays set until the next sequence starts.
- R9: out_of_idle_o is 1 exactly when mode_o is neither Off nor Idle.
- R10: rfctl_oe_o equals rfctl_en_i in every mode except Off, where it is 0. rfctl_o is 0 whenever rfctl_oe_o is 0.
- R11: In single-port operation (dual_port_i = 0), with the output enabled, rfctl_o is 1 in transmit warm-up and active and 0 in receive warm-up and active. rfctl_inv_i has no effect.
- R12: In dual-port operation, with the output enabled, rfctl_o is 1 for transmit and 0 for receive when rfctl_inv_i = 0, and the opposite when rfctl_inv_i = 1.
- R13: With the output enabled, rfctl_o is 0 in Idle, Hibernate and Doze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; holds the block in Off |
| rxtx_en_i | input | 1 | Sequence enable pin; a rising edge starts a sequence, a low level forces Idle |
| attn_n_i | input | 1 | Active-low attention pin; wakes the block from a low-power mode |
| lp_req_i | input | 2 | Low-power request: 01 Hibernate, 10 Doze, others none |
| seq_tx_i | input | 1 | Sequence direction: 0 receive, 1 transmit |
| seq_end_i | input | 1 | Strobe from the datapath that ends an active sequence |
| rfctl_en_i | input | 1 | RF control output enable |
| dual_port_i | input | 1 | 1 selects dual-port RF operation |
| rfctl_inv_i | input | 1 | RF control polarity inversion; applies in dual-port operation only |
| mode_o | output | 3 | Current mode, encoded as in R2 |
| out_of_idle_o | output | 1 | High when the mode is neither Off nor Idle |
| rfctl_o | output | 1 | RF control line value |
| rfctl_oe_o | output | 1 | RF control line output enable; 0 means high impedance |
| seq_done_o | output | 1 | One-cycle pulse when a sequence completes normally |
| seq_abort_o | output | 1 | Sticky flag: the last sequence was aborted |

## Verification
The assertions check, on every cycle, the legality of the state graph. Active phases are reached only through their warm-up, warm-ups and low-power modes are left from or entered from Idle only, and the done pulse and the abort flag coincide with a return to Idle from a sequence. The warm-up counter is also checked to stay in range. The bench's scenarios exercise the exact latencies of the synchronized pins, the exact length of the warm-up, and the rule that a held pin or an edge outside Idle starts nothing. They also exercise every row of the RF control truth table as the configuration bits change during a sequence.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  typedef enum logic [2:0] {
    M_OFF   = 3'd0,
    M_IDLE  = 3'd1,
    M_HIB   = 3'd2,
    M_DOZE  = 3'd3,
    M_RXW   = 3'd4,
    M_RX    = 3'd5,
    M_TXW   = 3'd6,
    M_TX    = 3'd7
  } rmc_mode_e;

  localparam logic [1:0] LP_REQ_HIB  = 2'b01;
  localparam logic [1:0] LP_REQ_DOZE = 2'b10;

  function automatic logic mode_is_tx(input rmc_mode_e m);
    return (m == M_TXW) || (m == M_TX);
  endfunction

  function automatic logic mode_is_rx(input rmc_mode_e m);
    return (m == M_RXW) || (m == M_RX);
  endfunction

  function automatic logic mode_is_seq(input rmc_mode_e m);
    return mode_is_tx(m) || mode_is_rx(m);
  endfunction

endpackage

// File: rtl/rmc_sync.sv
module rmc_sync #(
  parameter int              STAGES  = 2,
  parameter int              NPINS   = 2,
  parameter logic [NPINS-1:0] PIN_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  output logic             rst_q_n,
  output logic [NPINS-1:0] pins_o
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] rst_chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_chain_q <= '0;
    end else begin
      rst_chain_q <= {rst_chain_q[TOP-1:0], 1'b1};
    end
  end

  assign rst_q_n = rst_chain_q[TOP];

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        chain_q <= {STAGES{PIN_RST[gi]}};
      end else begin
        chain_q <= {chain_q[TOP-1:0], pins_i[gi]};
      end
    end

    assign pins_o[gi] = chain_q[TOP];
  end

endmodule

// File: rtl/rmc_warmup_timer.sv
module rmc_warmup_timer #(
  parameter int CYCLES = 2304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = LAST;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/rmc_mode_fsm.sv
module rmc_mode_fsm
  import rmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_s_i,
  input  logic       attn_n_s_i,
  input  logic [1:0] lp_req_i,
  input  logic       seq_tx_i,
  input  logic       seq_end_i,
  input  logic       tmr_expired_i,
  output logic       tmr_load_o,
  output logic       tmr_run_o,
  output rmc_mode_e  mode_o,
  output logic       seq_done_o,
  output logic       seq_abort_o
);

  rmc_mode_e state_q, state_d;
  logic      en_prev_q;
  logic      en_rise;
  logic      done_q, done_d;
  logic      abort_q, abort_d, abort_en;

  assign en_rise = en_s_i && !en_prev_q;

  always_comb begin
    state_d    = state_q;
    done_d     = 1'b0;
    abort_d    = abort_q;
    abort_en   = 1'b0;
    tmr_load_o = 1'b0;
    unique case (state_q)
      M_OFF: state_d = M_IDLE;
      M_IDLE: begin
        if (en_rise) begin
          state_d    = seq_tx_i ? M_TXW : M_RXW;
          tmr_load_o = 1'b1;
          abort_en   = 1'b1;
          abort_d    = 1'b0;
        end else if (attn_n_s_i) begin
          if (lp_req_i == LP_REQ_HIB) begin
            state_d = M_HIB;
          end else if (lp_req_i == LP_REQ_DOZE) begin
            state_d = M_DOZE;
          end
        end
      end
      M_HIB, M_DOZE: begin
        if (!attn_n_s_i) begin
          state_d = M_IDLE;
        end
      end
      M_RXW, M_TXW: begin
        if (!en_s_i) begin
          state_d  = M_IDLE;
          abort_en = 1'b1;
          abort_d  = 1'b1;
        end else if (tmr_expired_i) begin
          state_d = (state_q == M_TXW) ? M_TX : M_RX;
        end
      end
      M_RX, M_TX: begin
        if (!en_s_i) begin
          state_d  = M_IDLE;
          abort_en = 1'b1;
          abort_d  = 1'b1;
        end else if (seq_end_i) begin
          state_d = M_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = M_IDLE;
    endcase
  end

  assign tmr_run_o = (state_q == M_RXW) || (state_q == M_TXW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= M_OFF;
      en_prev_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      en_prev_q <= en_s_i;
      done_q    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
    end else if (abort_en) begin
      abort_q <= abort_d;
    end
  end

  assign mode_o      = state_q;
  assign seq_done_o  = done_q;
  assign seq_abort_o = abort_q;

  // R6
  rx_via_warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_RX && $past(state_q) != M_RX) |-> $past(state_q) == M_RXW);

  // R6
  tx_via_warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_TX && $past(state_q) != M_TX) |-> $past(state_q) == M_TXW);

  // R5
  warmup_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == M_RXW || state_q == M_TXW) && !$stable(state_q))
      |-> $past(state_q) == M_IDLE);

  // R3
  lowpower_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == M_HIB || state_q == M_DOZE) && !$stable(state_q))
      |-> $past(state_q) == M_IDLE);

  // R7
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (state_q == M_IDLE) &&
                   ($past(state_q) == M_RX || $past(state_q) == M_TX));

  // R8
  abort_on_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_abort_o) |-> (state_q == M_IDLE) && !seq_done_o &&
                           mode_is_seq($past(state_q)));

endmodule

// File: rtl/rmc_out_decode.sv
module rmc_out_decode
  import rmc_pkg::*;
(
  input  rmc_mode_e mode_i,
  input  logic      rfctl_en_i,
  input  logic      dual_port_i,
  input  logic      rfctl_inv_i,
  output logic      rfctl_o,
  output logic      rfctl_oe_o,
  output logic      out_of_idle_o
);

  logic seq_level;
  logic pol;

  assign pol = dual_port_i && rfctl_inv_i;

  always_comb begin
    seq_level = 1'b0;
    if (mode_is_tx(mode_i)) begin
      seq_level = !pol;
    end else if (mode_is_rx(mode_i)) begin
      seq_level = pol;
    end
  end

  assign rfctl_oe_o    = rfctl_en_i && (mode_i != M_OFF);
  assign rfctl_o       = rfctl_oe_o && seq_level;
  assign out_of_idle_o = (mode_i != M_OFF) && (mode_i != M_IDLE);

endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int WARMUP_CYCLES = 2304,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxtx_en_i,
  input  logic       attn_n_i,
  input  logic [1:0] lp_req_i,
  input  logic       seq_tx_i,
  input  logic       seq_end_i,
  input  logic       rfctl_en_i,
  input  logic       dual_port_i,
  input  logic       rfctl_inv_i,
  output logic [2:0] mode_o,
  output logic       out_of_idle_o,
  output logic       rfctl_o,
  output logic       rfctl_oe_o,
  output logic       seq_done_o,
  output logic       seq_abort_o
);

  localparam int NPINS = 2;

  logic             rst_q_n;
  logic [NPINS-1:0] pins_s;
  logic             tmr_load, tmr_run, tmr_expired;
  rmc_mode_e        mode;

  rmc_sync #(
    .STAGES  (SYNC_STAGES),
    .NPINS   (NPINS),
    .PIN_RST (2'b10)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_i  ({attn_n_i, rxtx_en_i}),
    .rst_q_n (rst_q_n),
    .pins_o  (pins_s)
  );

  rmc_warmup_timer #(
    .CYCLES (WARMUP_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load_i    (tmr_load),
    .run_i     (tmr_run),
    .expired_o (tmr_expired)
  );

  rmc_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .en_s_i        (pins_s[0]),
    .attn_n_s_i    (pins_s[1]),
    .lp_req_i      (lp_req_i),
    .seq_tx_i      (seq_tx_i),
    .seq_end_i     (seq_end_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_run_o     (tmr_run),
    .mode_o        (mode),
    .seq_done_o    (seq_done_o),
    .seq_abort_o   (seq_abort_o)
  );

  rmc_out_decode u_decode (
    .mode_i        (mode),
    .rfctl_en_i    (rfctl_en_i),
    .dual_port_i   (dual_port_i),
    .rfctl_inv_i   (rfctl_inv_i),
    .rfctl_o       (rfctl_o),
    .rfctl_oe_o    (rfctl_oe_o),
    .out_of_idle_o (out_of_idle_o)
  );

  assign mode_o = mode;

  // R9
  ooi_matches_mode_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_of_idle_o |-> (mode_o > 3'd1));

endmodule

// File: tb/radio_mode_ctrl_bench.sv
`timescale 1ns/100ps
module radio_mode_ctrl_bench;

  localparam int W = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, rxtx_en, attn_n, seq_tx, seq_end, rf_en, dual, inv;
  logic [1:0] lp_req;
  logic [2:0] mode;
  logic       ooi, rfv, rfoe, done, abort;

  radio_mode_ctrl #(.WARMUP_CYCLES(W)) u_radio_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .rxtx_en_i(rxtx_en), .attn_n_i(attn_n),
    .lp_req_i(lp_req), .seq_tx_i(seq_tx), .seq_end_i(seq_end),
    .rfctl_en_i(rf_en), .dual_port_i(dual), .rfctl_inv_i(inv),
    .mode_o(mode), .out_of_idle_o(ooi), .rfctl_o(rfv), .rfctl_oe_o(rfoe),
    .seq_done_o(done), .seq_abort_o(abort)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit r1, r2, e1, e2, ep, a1, a2, md, ma;
  int ms, mc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 = 0; r2 = 0; e1 = 0; e2 = 0; ep = 0; a1 = 1; a2 = 1;
      ms = 0; mc = 0; md = 0; ma = 0;
    end else begin : step_model
      bit live, rise, en_now, at_now;
      live   = r2;
      r2     = r1;
      r1     = 1;
      if (live) begin
        rise   = e2 && !ep;
        en_now = e2;
        at_now = a2;
        md     = 0;
        case (ms)
          0: ms = 1;
          1: begin
            if (rise) begin
              ms = seq_tx ? 6 : 4; mc = W - 1; ma = 0;
            end else if (at_now && lp_req == 2'b01) ms = 2;
            else if (at_now && lp_req == 2'b10) ms = 3;
          end
          2, 3: if (!at_now) ms = 1;
          4, 6: begin
            if (!en_now) begin ms = 1; ma = 1; end
            else if (mc == 0) ms = ms + 1;
            else mc = mc - 1;
          end
          default: begin
            if (!en_now) begin ms = 1; ma = 1; end
            else if (seq_end) begin ms = 1; md = 1; end
          end
        endcase
        ep = e2; e2 = e1; e1 = rxtx_en;
        a2 = a1; a1 = attn_n;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin : cmp
      int eoe, ev;
      bit tx, rx;
      tx  = (ms == 6 || ms == 7);
      rx  = (ms == 4 || ms == 5);
      eoe = (ms != 0 && rf_en) ? 1 : 0;
      ev  = 0;
      if (eoe == 1 && tx) ev = (dual && inv) ? 0 : 1;
      if (eoe == 1 && rx) ev = (dual && inv) ? 1 : 0;
      chk("R2 mode", int'(mode), ms);
      chk("R9 out_of_idle", int'(ooi), (ms >= 2) ? 1 : 0);
      chk("R10 rfctl_oe", int'(rfoe), eoe);
      chk(dual ? "R12 rfctl" : "R11 rfctl", int'(rfv), ev);
      chk("R7 seq_done", int'(done), int'(md));
      chk("R8 seq_abort", int'(abort), int'(ma));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    rst_n = 0; rxtx_en = 0; attn_n = 1; lp_req = 2'b00; seq_tx = 0;
    seq_end = 0; rf_en = 0; dual = 0; inv = 0;
    step(3);
    chk("R1 off in reset", int'(mode), 0);
    chk("R1 oe in reset", int'(rfoe), 0);
    rst_n = 1;
    step(2);
    chk("R1 still off", int'(mode), 0);
    step(1);
    chk("R1 idle after release", int'(mode), 1);

    rf_en = 1;
    step(1);
    chk("R13 idle oe", int'(rfoe), 1);
    chk("R13 idle low", int'(rfv), 0);

    // receive sequence, single port
    seq_tx = 0; rxtx_en = 1;
    step(3);
    chk("R5 rx warm-up", int'(mode), 4);
    chk("R11 rx low", int'(rfv), 0);
    step(W - 1);
    chk("R6 still warming", int'(mode), 4);
    step(1);
    chk("R6 rx active", int'(mode), 5);
    seq_end = 1;
    step(1);
    seq_end = 0;
    chk("R7 back idle", int'(mode), 1);
    chk("R7 done pulse", int'(done), 1);
    step(1);
    chk("R7 pulse one cycle", int'(done), 0);
    step(5);
    chk("R5 held pin no restart", int'(mode), 1);

    // transmit in dual port with inversion, then abort
    rxtx_en = 0;
    step(3);
    seq_tx = 1; dual = 1; inv = 1; rxtx_en = 1;
    step(3);
    chk("R5 tx warm-up", int'(mode), 6);
    chk("R12 tx inverted", int'(rfv), 0);
    inv = 0;
    step(1);
    chk("R12 tx plain", int'(rfv), 1);
    rxtx_en = 0;
    step(3);
    chk("R8 abort to idle", int'(mode), 1);
    chk("R8 abort flag", int'(abort), 1);
    chk("R8 no done", int'(done), 0);

    // receive dual inverted, abort in active
    seq_tx = 0; inv = 1; rxtx_en = 1;
    step(3);
    chk("R8 abort cleared", int'(abort), 0);
    chk("R12 rx inverted", int'(rfv), 1);
    step(W);
    chk("R6 rx active dual", int'(mode), 5);
    rxtx_en = 0;
    step(3);
    chk("R8 abort from active", int'(abort), 1);

    // single port ignores inversion
    dual = 0; inv = 1; seq_tx = 1; rxtx_en = 1;
    step(3);
    chk("R11 tx high inv ignored", int'(rfv), 1);
    step(W);
    chk("R6 tx active", int'(mode), 7);
    chk("R9 ooi active", int'(ooi), 1);
    rf_en = 0;
    step(1);
    chk("R10 disabled oe", int'(rfoe), 0);
    chk("R10 disabled value", int'(rfv), 0);
    rf_en = 1; rxtx_en = 0;
    step(3);
    chk("R8 idle", int'(mode), 1);

    // low-power modes
    lp_req = 2'b01;
    step(1);
    chk("R3 hibernate", int'(mode), 2);
    chk("R9 ooi hibernate", int'(ooi), 1);
    chk("R13 hibernate low", int'(rfv), 0);
    rxtx_en = 1;
    step(4);
    chk("R5 edge ignored", int'(mode), 2);
    rxtx_en = 0;
    step(3);
    attn_n = 0;
    step(3);
    chk("R4 wake", int'(mode), 1);
    step(2);
    chk("R4 attn blocks entry", int'(mode), 1);
    lp_req = 2'b10; attn_n = 1;
    step(3);
    chk("R3 doze", int'(mode), 3);
    lp_req = 2'b00; attn_n = 0;
    step(3);
    chk("R4 wake doze", int'(mode), 1);
    attn_n = 1;
    step(2);
    lp_req = 2'b11;
    step(4);
    chk("R3 code 11 no entry", int'(mode), 1);
    lp_req = 2'b00;

    rst_n = 0;
    #1;
    chk("R1 async off", int'(mode), 0);
    chk("R1 async oe", int'(rfoe), 0);
    step(2);
    wrap_up();
  end

endmodule